// File: doc/BRIEF.md
# AC-Link Frame Slot Serializer

This block is the controller end of a serial audio link to a single codec. It runs directly on the bit clock that the codec supplies. Frames repeat with no gap. Each frame is 256 bit clocks long and carries a 16-bit tag slot followed by twelve 20-bit data slots. The block drives the frame sync, shifts the outgoing frame onto the serial output, and gathers the incoming frame from the single serial input into parallel slot registers.

The host presents one tag word and twelve slot words on parallel inputs. These are captured at the start of every frame, so the host can change them at any point in a frame without disturbing the frame already on the wire. On the receive side, all slot registers are replaced at once when the last bit of slot 12 arrives, and a one-bit-clock strobe marks that moment.

Bit order, clock edges and sync polarity are fixed by the link. No input selects any other behaviour.

Top module: `aclink_frame_engine`

## Requirements
- R1: A frame lasts exactly 256 bit clocks: a 16-bit tag slot, then 12 slots of 20 bits. `sync_o` rises once every 256 rising edges.
- R2: `sync_o` is active high and stays high for 16 bit clocks. It rises one bit clock before the tag MSB is driven, while `sdata_o` still carries the last bit of the previous frame. It is low for the remaining 240 bit clocks.
- R3: The outgoing frame is sent MSB first, in this order: tag (`tx_tag_i[15]` first), then slot 1 through slot 12. Slot k is taken from `tx_slot_i[(k-1)*20 +: 20]`, and its bit 19 goes first.
- R4: `sdata_o` and `sync_o` change only on the rising edge of `bit_clk_i`, and hold steady across the falling edge.
- R5: `sdata_i` is sampled on the falling edge of `bit_clk_i`, MSB first, with the same slot layout as transmit. Received slot k appears on `rx_slot_o[(k-1)*20 +: 20]`, and the tag appears on `rx_tag_o`.
- R6: `rx_done_o` is high for exactly one bit clock. It rises on the falling edge that samples the last bit of slot 12. `rx_tag_o` and `rx_slot_o` all update on that same edge and hold their values at every other time.
- R7: `tx_tag_i` and `tx_slot_i` are captured on the rising edge that launches the tag MSB. Changes made later in the frame show up only in the next frame.
- R8: While `rst_ni` is low, all outputs are 0. After release:
  - the first rising edge raises `sync_o` with `sdata_o` at 0;
  - the second rising edge launches the tag MSB;
  - `rx_done_o` does not pulse until a complete frame has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Bit clock from the codec |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_o | output | 1 | Frame sync, active high, one tag slot long |
| sdata_o | output | 1 | Serial data to the codec |
| sdata_i | input | 1 | Serial data from the codec |
| tx_tag_i | input | 16 | Outgoing tag slot |
| tx_slot_i | input | 240 | Outgoing slots 1..12, slot k at bits (k-1)*20 +: 20 |
| rx_tag_o | output | 16 | Received tag slot |
| rx_slot_o | output | 240 | Received slots 1..12, same packing as transmit |
| rx_done_o | output | 1 | Receive frame complete strobe, one bit clock |

## Verification
The assertions check on every cycle the points where the sync changes level relative to the slot counter, the counter wrapping after 256 bits, the tag MSB following the frame-start edge, and the quiet output before the first frame. They also check, on the receive side, that the strobe is a single pulse aligned to the frame boundary and that the receive registers never change without it. The bench's scenarios show the rest:
- the full bit order of both directions under several data patterns;
- falling-edge sampling, shown by corrupting the input after each falling edge;
- the one-frame delay before a mid-frame host write takes effect;
- sync and data holding steady across the falling edge;
- restart after a reset applied mid-frame.

// File: rtl/aclink_pkg.sv
`timescale 1ns/1ps
package aclink_pkg;
  localparam int unsigned TAG_W_DEF      = 16;
  localparam int unsigned SLOT_W_DEF     = 20;
  localparam int unsigned DATA_SLOTS_DEF = 12;

  function automatic int unsigned frame_bits(int unsigned tag_w, int unsigned slot_w,
                                             int unsigned n_slots);
    return tag_w + slot_w * n_slots;
  endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
`timescale 1ns/1ps
module aclink_frame_timer #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned TAG_W     = 16,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             bit_clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             started_o,
  output logic             sync_o
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] PRE      = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(TAG_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_d;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_d  = wrap_o ? '0 : cnt_q + 1'b1;
  // high from one bit before tag MSB through tag bit 1
  assign sync_d = (cnt_d == LAST) || (cnt_d < SYNC_END);

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= PRE;
      sync_o    <= 1'b0;
      started_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sync_o    <= sync_d;
      started_o <= started_o | wrap_o;
    end
  end

  assign cnt_o = cnt_q;

  p_sync_rise_r2: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (cnt_q == LAST));
  p_sync_fall_r2: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> (cnt_q == SYNC_END));
  p_frame_wrap_r1: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0) && sync_o);
endmodule

// File: rtl/aclink_tx_serializer.sv
`timescale 1ns/1ps
module aclink_tx_serializer #(
  parameter int unsigned TAG_W      = 16,
  parameter int unsigned SLOT_W     = 20,
  parameter int unsigned DATA_SLOTS = 12,
  localparam int unsigned FRAME_LEN = TAG_W + SLOT_W * DATA_SLOTS
) (
  input  logic                         bit_clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [DATA_SLOTS*SLOT_W-1:0] slots_i,
  output logic                         sdata_o
);
  logic [FRAME_LEN-1:0] frame_w;
  logic [FRAME_LEN-1:0] shift_q;

  assign frame_w[FRAME_LEN-1 -: TAG_W] = tag_i;
  for (genvar k = 0; k < DATA_SLOTS; k++) begin : g_pack
    assign frame_w[FRAME_LEN-1-TAG_W-k*SLOT_W -: SLOT_W] = slots_i[k*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      sdata_o <= 1'b0;
    end else if (load_i) begin
      sdata_o <= frame_w[FRAME_LEN-1];
      shift_q <= {frame_w[FRAME_LEN-2:0], 1'b0};
    end else begin
      sdata_o <= shift_q[FRAME_LEN-1];
      shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/aclink_rx_deserializer.sv
`timescale 1ns/1ps
module aclink_rx_deserializer #(
  parameter int unsigned TAG_W      = 16,
  parameter int unsigned SLOT_W     = 20,
  parameter int unsigned DATA_SLOTS = 12,
  localparam int unsigned FRAME_LEN = TAG_W + SLOT_W * DATA_SLOTS,
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic                         bit_clk_i,
  input  logic                         rst_ni,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic                         started_i,
  input  logic                         sdata_i,
  output logic [TAG_W-1:0]             tag_o,
  output logic [DATA_SLOTS*SLOT_W-1:0] slots_o,
  output logic                         done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-2:0] shift_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic                 last_bit;

  assign last_bit = started_i && (cnt_i == LAST);

  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      frame_q <= '0;
      done_o  <= 1'b0;
    end else begin
      shift_q <= {shift_q[FRAME_LEN-3:0], sdata_i};
      done_o  <= last_bit;
      if (last_bit) frame_q <= {shift_q, sdata_i};
    end
  end

  assign tag_o = frame_q[FRAME_LEN-1 -: TAG_W];
  for (genvar k = 0; k < DATA_SLOTS; k++) begin : g_unpack
    assign slots_o[k*SLOT_W +: SLOT_W] = frame_q[FRAME_LEN-1-TAG_W-k*SLOT_W -: SLOT_W];
  end

  p_done_at_boundary_r6: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_i == '0));
  p_done_single_r6: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_rx_hold_r6: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(tag_o) && $stable(slots_o)));
endmodule

// File: rtl/aclink_frame_engine.sv
`timescale 1ns/1ps
module aclink_frame_engine
  import aclink_pkg::*;
#(
  parameter int unsigned TAG_W      = TAG_W_DEF,
  parameter int unsigned SLOT_W     = SLOT_W_DEF,
  parameter int unsigned DATA_SLOTS = DATA_SLOTS_DEF,
  localparam int unsigned FRAME_LEN = frame_bits(TAG_W, SLOT_W, DATA_SLOTS),
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN),
  localparam int unsigned PAY_W     = DATA_SLOTS * SLOT_W
) (
  input  logic             bit_clk_i,
  input  logic             rst_ni,
  output logic             sync_o,
  output logic             sdata_o,
  input  logic             sdata_i,
  input  logic [TAG_W-1:0] tx_tag_i,
  input  logic [PAY_W-1:0] tx_slot_i,
  output logic [TAG_W-1:0] rx_tag_o,
  output logic [PAY_W-1:0] rx_slot_o,
  output logic             rx_done_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             started;

  aclink_frame_timer #(.FRAME_LEN(FRAME_LEN), .TAG_W(TAG_W)) timer_i (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (cnt),
    .wrap_o    (wrap),
    .started_o (started),
    .sync_o    (sync_o)
  );

  aclink_tx_serializer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .DATA_SLOTS(DATA_SLOTS)) tx_i (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wrap),
    .tag_i     (tx_tag_i),
    .slots_i   (tx_slot_i),
    .sdata_o   (sdata_o)
  );

  aclink_rx_deserializer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .DATA_SLOTS(DATA_SLOTS)) rx_i (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .started_i (started),
    .sdata_i   (sdata_i),
    .tag_o     (rx_tag_o),
    .slots_o   (rx_slot_o),
    .done_o    (rx_done_o)
  );

  p_tag_launch_r3: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    wrap |=> (sdata_o == $past(tx_tag_i[TAG_W-1])));
  p_quiet_before_frame_r8: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !started |-> !sdata_o);
endmodule

// File: tb/aclink_frame_engine_tb_top.sv
`timescale 1ns/1ps
module aclink_frame_engine_tb_top;
  localparam int NV = 4;
  localparam logic [15:0] TX_TAG  [NV] = '{16'hF800, 16'hFFFF, 16'h0000, 16'hA5C3};
  localparam logic [19:0] TX_SEED [NV] = '{20'h12345, 20'hFFFFF, 20'h00000, 20'h5A5A5};
  localparam logic [15:0] RX_TAG  [NV] = '{16'h9C00, 16'h0000, 16'hFFFF, 16'h3C5A};
  localparam logic [19:0] RX_SEED [NV] = '{20'hABCDE, 20'h00000, 20'hFFFFF, 20'hA5A5A};

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sync_o, sdata_o, rx_done_o;
  logic         sdata_i = 1'b0;
  logic [15:0]  tx_tag_i = '0, rx_tag_o;
  logic [239:0] tx_slot_i = '0, rx_slot_o;
  int checks = 0;
  int errors = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  aclink_frame_engine dut_i (
    .bit_clk_i (clk), .rst_ni (rst_ni), .sync_o (sync_o), .sdata_o (sdata_o),
    .sdata_i (sdata_i), .tx_tag_i (tx_tag_i), .tx_slot_i (tx_slot_i),
    .rx_tag_o (rx_tag_o), .rx_slot_o (rx_slot_o), .rx_done_o (rx_done_o)
  );

  function automatic logic [239:0] mk_slots(logic [19:0] seed);
    logic [239:0] s;
    for (int k = 1; k <= 12; k++) s[(k-1)*20 +: 20] = seed ^ (20'(k) * 20'h11111);
    return s;
  endfunction

  function automatic logic [255:0] pack(logic [15:0] tag, logic [239:0] s);
    logic [255:0] f;
    f[255 -: 16] = tag;
    for (int k = 1; k <= 12; k++) f[255-16-(k-1)*20 -: 20] = s[(k-1)*20 +: 20];
    return f;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic set_tx(input int k);
    tx_tag_i  = TX_TAG[k];
    tx_slot_i = mk_slots(TX_SEED[k]);
  endtask

  // called right after the sample where sync has risen ahead of the frame
  task automatic run_frame(input int k, input bit prev_valid, input logic [255:0] prev_rx);
    logic [255:0] txv, rxv, got;
    logic [1:0]   a;
    int sync_err = 0, unstable = 0, done_err = 0;
    txv = pack(TX_TAG[k], mk_slots(TX_SEED[k]));
    rxv = pack(RX_TAG[k], mk_slots(RX_SEED[k]));
    got = '0;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk);
      #0.5 sdata_i = rxv[255-i];
      #0.5 got[255-i] = sdata_o;
      if (sync_o != ((i < 15) || (i == 255))) sync_err++;
      a = {sync_o, sdata_o};
      if (i == 0) begin
        chk(rx_done_o == prev_valid, "R6 R8 rx_done at frame boundary",
            256'(rx_done_o), 256'(prev_valid));
        if (prev_valid)
          chk(pack(rx_tag_o, rx_slot_o) == prev_rx, "R5 rx slots after done",
              pack(rx_tag_o, rx_slot_o), prev_rx);
      end else if (rx_done_o) done_err++;
      if (i == 100) set_tx((k + 1) % NV);
      if (i == 200 && prev_valid)
        chk(pack(rx_tag_o, rx_slot_o) == prev_rx, "R6 rx hold mid-frame",
            pack(rx_tag_o, rx_slot_o), prev_rx);
      #2 sdata_i = ~rxv[255-i];  // corrupt after falling edge: R5
      #1 if ({sync_o, sdata_o} != a) unstable++;
    end
    chk(got == txv, "R3 R7 tx stream", got, txv);
    chk(sync_err == 0, "R1 R2 sync timing errors", 256'(sync_err), 256'(0));
    chk(unstable == 0, "R4 output change near falling edge", 256'(unstable), 256'(0));
    chk(done_err == 0, "R6 stray rx_done", 256'(done_err), 256'(0));
  endtask

  initial begin
    #200000;
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] rxv;
    #12;
    chk({sync_o, sdata_o, rx_done_o} == 3'b000 && rx_tag_o == '0 && rx_slot_o == '0,
        "R8 reset state", 256'({sync_o, sdata_o, rx_done_o}), 256'(0));
    set_tx(0);
    @(negedge clk); #0.5 rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(sync_o && !sdata_o, "R8 R2 first sync ahead of tag", 256'({sync_o, sdata_o}), 256'(2'b10));
    for (int k = 0; k < NV; k++)
      run_frame(k, k > 0, pack(RX_TAG[(k+NV-1)%NV], mk_slots(RX_SEED[(k+NV-1)%NV])));
    rxv = pack(RX_TAG[NV-1], mk_slots(RX_SEED[NV-1]));
    @(posedge clk); #1;
    chk(rx_done_o == 1'b1, "R6 last frame done", 256'(rx_done_o), 256'(1));
    chk(pack(rx_tag_o, rx_slot_o) == rxv, "R5 last frame rx data", pack(rx_tag_o, rx_slot_o), rxv);
    @(posedge clk); #1;
    chk(rx_done_o == 1'b0, "R6 done single pulse", 256'(rx_done_o), 256'(0));
    // reset in the middle of a frame
    repeat (37) @(posedge clk);
    #1 rst_ni = 1'b0;
    #1;
    chk({sync_o, sdata_o, rx_done_o} == 3'b000 && rx_tag_o == '0 && rx_slot_o == '0,
        "R8 mid-frame reset clears", 256'({sync_o, sdata_o, rx_done_o}), 256'(0));
    set_tx(1);
    @(negedge clk); #0.5 rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(sync_o && !sdata_o, "R8 restart sync", 256'({sync_o, sdata_o}), 256'(2'b10));
    run_frame(1, 1'b0, '0);
    rxv = pack(RX_TAG[1], mk_slots(RX_SEED[1]));
    @(posedge clk); #1;
    chk(rx_done_o == 1'b1 && pack(rx_tag_o, rx_slot_o) == rxv, "R6 R5 first frame after reset",
        pack(rx_tag_o, rx_slot_o), rxv);
    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule